// File: doc/BRIEF.md
# Four-CPU Interrupt Distributor

This block gathers interrupt requests for a cluster of four processors and decides which processor takes each one. There are three kinds of source. Software raises inter-processor interrupts (IDs 0 to 15) by writing a send command. Each CPU has its own timer and watchdog lines, which appear as IDs 29 and 30 of that CPU. Thirty-two shared hardware lines appear as IDs 32 to 63. Every interrupt has an enable bit and a 4-bit priority. Each shared line also has a 4-bit target mask, which sends it to one CPU, to a group of CPUs, or to all four.

For every CPU the block keeps a separate state for each ID: inactive, pending or active. Each CPU has an acknowledge strobe. The strobe returns the best eligible interrupt and marks it active for that CPU. Each CPU also has an end-of-interrupt strobe, which ends the handling of an ID. A per-CPU request line is raised whenever some interrupt would win an acknowledge. An interrupt can win only if its priority is better than the CPU's priority mask and strictly better than every interrupt the CPU already has active. This second condition is what allows nested preemption.

Configuration uses a write strobe, a 9-bit address and a combinational read-back path.

Top module: `mp_irq_distributor`

## Requirements
- R1: After reset, no interrupt is pending or active on any CPU, every irq_out bit is 0, every ack_id field reads 1023, every enable and priority is 0, and every CPU priority mask is 15.
- R2: When addr[8]=0, the address is {addr[7:6]=cpu, addr[5:0]=id}. The config word holds prio in bits [3:0], enable in bit [4] and target mask in bits [11:8]. For IDs below 32 the word is banked per CPU and has no target field. For IDs 32 to 63 a single word is shared by all CPUs and the cpu field is ignored. Writes to either kind read back unchanged.
- R3: A write to addr {1'b1, src, 6'b000000} sends inter-processor interrupt wdata[3:0] from CPU src. The mode is wdata[5:4]. Mode 0 targets the CPUs in the list wdata[11:8]. Mode 1 targets every CPU except src. Mode 2 targets src only. Mode 3 targets nothing.
- R4: An inter-processor interrupt uses the priority and enable bit held in the target CPU's bank, not those in the sender's bank.
- R5: The ack_id field of a CPU is loaded at the clock edge where that CPU's ack_rd is sampled high. It keeps its value until the next acknowledge.
- R6: An acknowledge returns the eligible ID with the numerically lowest priority, and the lowest ID wins a tie. It moves that ID from pending to active for that CPU, or returns 1023 when no ID is eligible.
- R7: Shared line n is pending on CPU c while spi_in[n] is high, bit c of the target mask of ID 32+n is set, and ID 32+n is not active on c.
- R8: On CPU c, ID 29 follows ppi_timer[c] and ID 30 follows ppi_wdog[c] as level sources. Neither one affects any other CPU.
- R9: An interrupt is eligible only if its priority is strictly below the priority mask of its CPU. The mask is written at addr {1'b1, cpu, 6'b000001} using bits [3:0].
- R10: An interrupt is eligible only if its priority is strictly below that of every interrupt active on the same CPU. irq_out[c] is high exactly when CPU c has an eligible interrupt.
- R11: An interrupt whose enable bit is 0 is never eligible. It stays pending and becomes eligible once its enable bit is set.
- R12: eoi_wr[c] with eoi_id[c] ends the active state of that ID on CPU c. A level source that is still high is pending again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_in | input | 32 | Shared hardware interrupt levels, bit n is ID 32+n |
| ppi_timer | input | 4 | Per-CPU timer level, ID 29 |
| ppi_wdog | input | 4 | Per-CPU watchdog level, ID 30 |
| ack_rd | input | 4 | Per-CPU acknowledge strobe |
| ack_id | output | 40 | Per-CPU acknowledged ID, 10 bits per CPU, CPU 0 in the low bits |
| eoi_wr | input | 4 | Per-CPU end-of-interrupt strobe |
| eoi_id | input | 24 | Per-CPU end-of-interrupt ID, 6 bits per CPU |
| irq_out | output | 4 | Per-CPU request line |

## Verification
A configuration write or a send command takes effect at the clock edge where the strobe is sampled. irq_out is a combinational function of registered state and the level inputs, so it reflects a new state right after that edge and reflects a change on spi_in, ppi_timer or ppi_wdog within the same cycle. An acknowledge loads ack_id at the edge where ack_rd is sampled. The bench raises every strobe at a falling edge and drops it at the next falling edge. It samples ack_id and irq_out at that second falling edge, or a step after an input change, so each read falls one half cycle after the edge that produced the result.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
    localparam int NCPU   = 4;
    localparam int NID    = 64;
    localparam int NPRIV  = 32;
    localparam int NSHR   = NID - NPRIV;
    localparam int NSGI   = 16;
    localparam int PW     = 4;
    localparam int IDW    = $clog2(NID);
    localparam int CPUW   = $clog2(NCPU);
    localparam int ACKW   = 10;
    localparam int AW     = 1 + CPUW + IDW;
    localparam int DW     = 32;
    localparam int ID_TMR = 29;
    localparam int ID_WDG = 30;
    localparam logic [ACKW-1:0] SPURIOUS = 10'd1023;

    typedef enum logic [1:0] {
        SEND_LIST   = 2'd0,
        SEND_OTHERS = 2'd1,
        SEND_SELF   = 2'd2,
        SEND_NONE   = 2'd3
    } send_mode_e;

    typedef struct packed {
        logic [NCPU-1:0][NPRIV-1:0][PW-1:0] priv_prio;
        logic [NCPU-1:0][NPRIV-1:0]         priv_en;
        logic [NSHR-1:0][PW-1:0]            shr_prio;
        logic [NSHR-1:0]                    shr_en;
        logic [NSHR-1:0][NCPU-1:0]          shr_tgt;
        logic [NCPU-1:0][PW-1:0]            pmask;
    } cfg_t;

    typedef struct packed {
        logic [NCPU-1:0][NSGI-1:0] sgi_pend;
        logic [NCPU-1:0][NID-1:0]  act;
        logic [NCPU-1:0][ACKW-1:0] ack_id;
    } core_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_dist_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_we,
    input  logic [AW-1:0]                      reg_addr,
    input  logic [DW-1:0]                      reg_wdata,
    output logic [DW-1:0]                      reg_rdata,
    output logic [NCPU-1:0][NID-1:0][PW-1:0]   prio_map,
    output logic [NCPU-1:0][NID-1:0]           en_map,
    output logic [NSHR-1:0][NCPU-1:0]          shr_tgt,
    output logic [NCPU-1:0][PW-1:0]            pmask,
    output logic                               sgi_go,
    output logic [NCPU-1:0]                    sgi_dst,
    output logic [3:0]                         sgi_id
);
    localparam cfg_t CFG_RST = '{priv_prio: '0, priv_en: '0, shr_prio: '0,
                                 shr_en: '0, shr_tgt: '0,
                                 pmask: {(NCPU*PW){1'b1}}};

    cfg_t cfg_d, cfg_q;

    logic            is_ctl;
    logic [CPUW-1:0] a_cpu;
    logic [IDW-1:0]  a_id;
    logic [4:0]      a_sub;
    logic [1:0]      ctl_sel;
    send_mode_e      mode;

    assign is_ctl  = reg_addr[AW-1];
    assign a_cpu   = reg_addr[IDW +: CPUW];
    assign a_id    = reg_addr[IDW-1:0];
    assign a_sub   = a_id[4:0];
    assign ctl_sel = reg_addr[1:0];
    assign mode    = send_mode_e'(reg_wdata[5:4]);

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we && !is_ctl) begin
            if (!a_id[IDW-1]) begin
                cfg_d.priv_prio[a_cpu][a_sub] = reg_wdata[PW-1:0];
                cfg_d.priv_en[a_cpu][a_sub]   = reg_wdata[4];
            end else begin
                cfg_d.shr_prio[a_sub] = reg_wdata[PW-1:0];
                cfg_d.shr_en[a_sub]   = reg_wdata[4];
                cfg_d.shr_tgt[a_sub]  = reg_wdata[8 +: NCPU];
            end
        end
        if (reg_we && is_ctl && ctl_sel == 2'd1)
            cfg_d.pmask[a_cpu] = reg_wdata[PW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    // send command decode
    always_comb begin
        sgi_go  = reg_we && is_ctl && ctl_sel == 2'd0 && mode != SEND_NONE;
        sgi_id  = reg_wdata[3:0];
        case (mode)
            SEND_LIST:   sgi_dst = reg_wdata[8 +: NCPU];
            SEND_OTHERS: sgi_dst = ~(NCPU'(1) << a_cpu);
            SEND_SELF:   sgi_dst = NCPU'(1) << a_cpu;
            default:     sgi_dst = '0;
        endcase
    end

    // flatten config into per-CPU views over the whole ID space
    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            for (int i = 0; i < NID; i++) begin
                if (i < NPRIV) begin
                    prio_map[c][i] = cfg_q.priv_prio[c][i];
                    en_map[c][i]   = cfg_q.priv_en[c][i];
                end else begin
                    prio_map[c][i] = cfg_q.shr_prio[i-NPRIV];
                    en_map[c][i]   = cfg_q.shr_en[i-NPRIV];
                end
            end
        end
    end

    assign shr_tgt = cfg_q.shr_tgt;
    assign pmask   = cfg_q.pmask;

    always_comb begin
        reg_rdata = '0;
        if (!is_ctl) begin
            if (!a_id[IDW-1]) begin
                reg_rdata[PW-1:0] = cfg_q.priv_prio[a_cpu][a_sub];
                reg_rdata[4]      = cfg_q.priv_en[a_cpu][a_sub];
            end else begin
                reg_rdata[PW-1:0]     = cfg_q.shr_prio[a_sub];
                reg_rdata[4]          = cfg_q.shr_en[a_sub];
                reg_rdata[8 +: NCPU]  = cfg_q.shr_tgt[a_sub];
            end
        end else if (ctl_sel == 2'd1) begin
            reg_rdata[PW-1:0] = cfg_q.pmask[a_cpu];
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_dist_pkg::*;
(
    input  logic [NID-1:0]          cand,
    input  logic [NID-1:0][PW-1:0]  prio,
    input  logic [NID-1:0]          act,
    input  logic [PW-1:0]           pmask,
    output logic [IDW-1:0]          best_id,
    output logic                    best_ok
);
    logic [PW:0] run_p;
    logic [PW:0] best_p;
    logic        found;

    always_comb begin
        run_p = {1'b1, {PW{1'b0}}};
        for (int i = 0; i < NID; i++)
            if (act[i] && {1'b0, prio[i]} < run_p) run_p = {1'b0, prio[i]};
    end

    // strict compare while scanning upward keeps the lowest ID on ties
    always_comb begin
        best_p  = {1'b1, {PW{1'b0}}};
        best_id = '0;
        found   = 1'b0;
        for (int i = 0; i < NID; i++) begin
            if (cand[i] && {1'b0, prio[i]} < best_p) begin
                best_p  = {1'b0, prio[i]};
                best_id = IDW'(i);
                found   = 1'b1;
            end
        end
        best_ok = found && (best_p < {1'b0, pmask}) && (best_p < run_p);
    end
endmodule

// File: rtl/mp_irq_distributor.sv
module mp_irq_distributor
    import irq_dist_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [8:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [31:0]          spi_in,
    input  logic [3:0]           ppi_timer,
    input  logic [3:0]           ppi_wdog,
    input  logic [3:0]           ack_rd,
    output logic [39:0]          ack_id,
    input  logic [3:0]           eoi_wr,
    input  logic [23:0]          eoi_id,
    output logic [3:0]           irq_out
);
    localparam core_t CORE_RST = '{sgi_pend: '0, act: '0,
                                   ack_id: {NCPU{SPURIOUS}}};

    logic [NCPU-1:0][NID-1:0][PW-1:0] prio_map;
    logic [NCPU-1:0][NID-1:0]         en_map;
    logic [NSHR-1:0][NCPU-1:0]        shr_tgt;
    logic [NCPU-1:0][PW-1:0]          pmask;
    logic                             sgi_go;
    logic [NCPU-1:0]                  sgi_dst;
    logic [3:0]                       sgi_id;

    logic [NCPU-1:0][NID-1:0]         pend;
    logic [NCPU-1:0][NID-1:0]         cand;
    logic [NCPU-1:0][IDW-1:0]         best_id;
    logic [NCPU-1:0]                  best_ok;
    logic [NCPU-1:0][IDW-1:0]         eoi_v;

    core_t st_d, st_q;

    assign eoi_v = eoi_id;

    irq_cfg_regs i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .prio_map (prio_map),
        .en_map   (en_map),
        .shr_tgt  (shr_tgt),
        .pmask    (pmask),
        .sgi_go   (sgi_go),
        .sgi_dst  (sgi_dst),
        .sgi_id   (sgi_id)
    );

    // per-CPU pending view: latched software IDs, level private and shared lines
    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            for (int i = 0; i < NID; i++) begin
                if (i < NSGI)        pend[c][i] = st_q.sgi_pend[c][i];
                else if (i == ID_TMR) pend[c][i] = ppi_timer[c];
                else if (i == ID_WDG) pend[c][i] = ppi_wdog[c];
                else if (i >= NPRIV) pend[c][i] = spi_in[i-NPRIV] & shr_tgt[i-NPRIV][c];
                else                 pend[c][i] = 1'b0;
            end
            cand[c] = pend[c] & ~st_q.act[c] & en_map[c];
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        irq_pick i_pick (
            .cand   (cand[c]),
            .prio   (prio_map[c]),
            .act    (st_q.act[c]),
            .pmask  (pmask[c]),
            .best_id(best_id[c]),
            .best_ok(best_ok[c])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCPU; c++) begin
            if (eoi_wr[c]) st_d.act[c][eoi_v[c]] = 1'b0;
            if (ack_rd[c]) begin
                if (best_ok[c]) begin
                    st_d.ack_id[c]           = ACKW'(best_id[c]);
                    st_d.act[c][best_id[c]]  = 1'b1;
                    if (int'(best_id[c]) < NSGI)
                        st_d.sgi_pend[c][best_id[c][3:0]] = 1'b0;
                end else begin
                    st_d.ack_id[c] = SPURIOUS;
                end
            end
            if (sgi_go && sgi_dst[c]) st_d.sgi_pend[c][sgi_id] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CORE_RST;
        else        st_q <= st_d;
    end

    assign ack_id  = st_q.ack_id;
    assign irq_out = best_ok;
endmodule

// File: rtl/mp_irq_distributor_chk.sv
module mp_irq_distributor_chk
    import irq_dist_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [3:0]              ack_rd,
    input logic [3:0]              irq_out,
    input logic [39:0]             ack_id,
    input logic [NCPU-1:0][PW-1:0] pmask
);
    for (genvar c = 0; c < NCPU; c++) begin : g_c
        p_ack_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_rd[c] && !irq_out[c]) |=> ack_id[c*ACKW +: ACKW] == SPURIOUS);
        p_ack_real_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_rd[c] && irq_out[c]) |=> ack_id[c*ACKW +: ACKW] < ACKW'(NID));
        p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !ack_rd[c] |=> $stable(ack_id[c*ACKW +: ACKW]));
        p_mask_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pmask[c] == '0) |-> !irq_out[c]);
    end
endmodule

bind mp_irq_distributor mp_irq_distributor_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack_rd (ack_rd),
    .irq_out(irq_out),
    .ack_id (ack_id),
    .pmask  (pmask)
);

// File: tb/test_mp_irq_distributor.sv
module test_mp_irq_distributor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] spi_in = '0;
    logic [3:0]  ppi_timer = '0;
    logic [3:0]  ppi_wdog = '0;
    logic [3:0]  ack_rd = '0;
    logic [39:0] ack_id;
    logic [3:0]  eoi_wr = '0;
    logic [23:0] eoi_id = '0;
    logic [3:0]  irq_out;

    int nvec = 0;
    int nbad = 0;

    always #5 clk = ~clk;

    mp_irq_distributor i_mp_irq_distributor (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_in(spi_in),
        .ppi_timer(ppi_timer), .ppi_wdog(ppi_wdog), .ack_rd(ack_rd),
        .ack_id(ack_id), .eoi_wr(eoi_wr), .eoi_id(eoi_id), .irq_out(irq_out)
    );

    task automatic chk(string tag, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; spi_in = '0; ppi_timer = '0; ppi_wdog = '0;
        ack_rd = '0; eoi_wr = '0; reg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [8:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    task automatic cfg_p(int cpu, int id, int prio, int en);
        wr({1'b0, 2'(cpu), 6'(id)}, {27'd0, 1'(en), 4'(prio)});
    endtask

    task automatic cfg_s(int id, int tgt, int prio, int en);
        wr({1'b0, 2'd0, 6'(id)}, {20'd0, 4'(tgt), 3'd0, 1'(en), 4'(prio)});
    endtask

    task automatic send(int src, int mode, int lst, int id);
        wr({1'b1, 2'(src), 6'd0}, {20'd0, 4'(lst), 2'd0, 2'(mode), 4'(id)});
    endtask

    task automatic set_pm(int cpu, int v);
        wr({1'b1, 2'(cpu), 6'd1}, {28'd0, 4'(v)});
    endtask

    task automatic ack(int c, output int id);
        @(negedge clk);
        ack_rd[c] = 1'b1;
        @(negedge clk);
        ack_rd[c] = 1'b0;
        id = int'(ack_id[c*10 +: 10]);
    endtask

    task automatic eoi(int c, int id);
        @(negedge clk);
        eoi_wr[c] = 1'b1; eoi_id[c*6 +: 6] = 6'(id);
        @(negedge clk);
        eoi_wr[c] = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        #1 chk("R1 irq_out", int'(irq_out), 0);
        for (int c = 0; c < 4; c++) begin
            ack(c, v); chk("R1 ack spurious", v, 1023);
            rd({1'b1, 2'(c), 6'd1}, v); chk("R1 pmask", v, 15);
        end
        rd({1'b0, 2'd1, 6'd40}, v); chk("R1 cfg zero", v, 0);
    endtask

    task automatic t_cfg();
        int v;
        do_reset();
        cfg_p(2, 5, 7, 1);
        rd({1'b0, 2'd2, 6'd5}, v); chk("R2 banked readback", v, 'h17);
        rd({1'b0, 2'd1, 6'd5}, v); chk("R2 other bank", v, 0);
        cfg_s(40, 'hA, 3, 1);
        rd({1'b0, 2'd3, 6'd40}, v); chk("R2 shared readback", v, 'hA13);
    endtask

    task automatic t_sgi_modes();
        int v;
        do_reset();
        for (int c = 0; c < 4; c++) cfg_p(c, 3, 2, 1);
        send(1, 1, 0, 3);
        for (int c = 0; c < 4; c++) begin
            ack(c, v); chk("R3 all-but-self", v, (c == 1) ? 1023 : 3);
            if (c != 1) eoi(c, 3);
        end
        send(2, 2, 0, 3);
        ack(0, v); chk("R3 self other cpu", v, 1023);
        ack(2, v); chk("R3 self", v, 3);
        eoi(2, 3);
        send(3, 0, 'b0011, 3);
        ack(0, v); chk("R3 list cpu0", v, 3);
        ack(1, v); chk("R3 list cpu1", v, 3);
        ack(3, v); chk("R3 list sender", v, 1023);
        eoi(0, 3); eoi(1, 3);
        send(0, 3, 'b1111, 3);
        #1 chk("R3 mode3 none", int'(irq_out), 0);
    endtask

    task automatic t_sgi_prio();
        int v;
        do_reset();
        cfg_p(0, 4, 9, 1); cfg_p(1, 4, 1, 1);
        cfg_p(0, 6, 5, 1); cfg_p(1, 6, 5, 1);
        cfg_p(2, 4, 0, 1); cfg_p(2, 6, 15, 1);
        send(2, 0, 'b0011, 4);
        send(2, 0, 'b0011, 6);
        ack(0, v); chk("R4 target prio cpu0", v, 6);
        ack(1, v); chk("R4 target prio cpu1", v, 4);
    endtask

    task automatic t_spi();
        int v;
        do_reset();
        cfg_s(33, 'b0100, 2, 1);
        @(negedge clk); spi_in[1] = 1'b1;
        #1 chk("R7 routed cpu2", int'(irq_out), 'b0100);
        ack(2, v); chk("R7 ack shared", v, 33);
        #1 chk("R7 active not pending", int'(irq_out[2]), 0);
        @(negedge clk); spi_in[1] = 1'b0;
        eoi(2, 33);
        cfg_s(33, 'b1111, 2, 1);
        @(negedge clk); spi_in[1] = 1'b1;
        #1 chk("R7 all cpus", int'(irq_out), 'b1111);
        @(negedge clk); spi_in[1] = 1'b0;
        #1 chk("R7 level drop", int'(irq_out), 0);
    endtask

    task automatic t_ppi();
        int v;
        do_reset();
        cfg_p(1, 29, 3, 1);
        cfg_p(3, 30, 3, 1);
        @(negedge clk); ppi_timer = 4'b0011; ppi_wdog = 4'b1000;
        ack(1, v); chk("R8 timer cpu1", v, 29);
        ack(0, v); chk("R8 timer cpu0 disabled", v, 1023);
        ack(3, v); chk("R8 watchdog cpu3", v, 30);
        ack(2, v); chk("R8 cpu2 untouched", v, 1023);
    endtask

    task automatic t_order();
        int v;
        do_reset();
        cfg_p(0, 7, 4, 1); cfg_p(0, 8, 2, 1); cfg_p(0, 9, 2, 1);
        send(0, 2, 0, 9); send(0, 2, 0, 7); send(0, 2, 0, 8);
        ack(0, v); chk("R6 best prio tie low id", v, 8);
        repeat (3) @(negedge clk);
        chk("R5 ack_id held", int'(ack_id[9:0]), 8);
        eoi(0, 8);
        ack(0, v); chk("R6 tie second", v, 9);
        eoi(0, 9);
        ack(0, v); chk("R6 lowest last", v, 7);
        eoi(0, 7);
        ack(0, v); chk("R6 empty", v, 1023);
    endtask

    task automatic t_pmask();
        int v;
        do_reset();
        cfg_p(0, 10, 5, 1);
        set_pm(0, 5);
        send(0, 2, 0, 10);
        #1 chk("R9 mask equal blocks", int'(irq_out[0]), 0);
        ack(0, v); chk("R9 blocked ack", v, 1023);
        set_pm(0, 6);
        ack(0, v); chk("R9 mask above passes", v, 10);
    endtask

    task automatic t_preempt();
        int v;
        do_reset();
        cfg_p(0, 11, 6, 1); cfg_p(0, 12, 6, 1); cfg_p(0, 13, 3, 1);
        send(0, 2, 0, 11);
        ack(0, v); chk("R10 first", v, 11);
        send(0, 2, 0, 12);
        #1 chk("R10 equal no preempt", int'(irq_out[0]), 0);
        ack(0, v); chk("R10 equal ack", v, 1023);
        send(0, 2, 0, 13);
        #1 chk("R10 higher irq", int'(irq_out[0]), 1);
        ack(0, v); chk("R10 preempt", v, 13);
        eoi(0, 13); eoi(0, 11);
        ack(0, v); chk("R10 resumed", v, 12);
    endtask

    task automatic t_enable();
        int v;
        do_reset();
        cfg_p(0, 14, 1, 0);
        send(0, 2, 0, 14);
        #1 chk("R11 disabled irq", int'(irq_out[0]), 0);
        ack(0, v); chk("R11 disabled ack", v, 1023);
        cfg_p(0, 14, 1, 1);
        ack(0, v); chk("R11 held pending", v, 14);
    endtask

    task automatic t_eoi();
        int v;
        do_reset();
        cfg_s(50, 'b0001, 1, 1);
        @(negedge clk); spi_in[18] = 1'b1;
        ack(0, v); chk("R12 first take", v, 50);
        eoi(0, 50);
        #1 chk("R12 level repending", int'(irq_out[0]), 1);
        ack(0, v); chk("R12 retake", v, 50);
        @(negedge clk); spi_in[18] = 1'b0;
        eoi(0, 50);
        #1 chk("R12 inactive", int'(irq_out[0]), 0);
        ack(0, v); chk("R12 nothing", v, 1023);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        t_reset();
        t_cfg();
        t_sgi_modes();
        t_sgi_prio();
        t_spi();
        t_ppi();
        t_order();
        t_pmask();
        t_preempt();
        t_enable();
        t_eoi();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule